// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupt Detection

This block is a 32-pin general-purpose I/O bank for a simple register bus. The bus has an address, a write strobe, write data and combinational read data. Software uses it to choose each pin's direction and to drive output values. Output bits can be changed one mask at a time through set and clear aliases. Software also reads the pad levels after they pass through a synchronizer.

Every pin has four detect-enable bits: rising edge, falling edge, low level and high level. The enabled conditions are OR-combined into one event per pin. Events are recorded in a sticky status register that software clears by writing ones. A per-pin interrupt enable, changed only through set and clear aliases, decides which pending bits reach the single interrupt output.

Any write to a detect-enable register starts a short quiet window. During that window no new event is recorded, so the synchronizer and edge pipeline can settle without producing false events.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin is an input (direction register all ones, pad_oe all zero). The output data, all detect-enable, interrupt-enable and status registers are zero, and irq is low.
- R2: Direction register (offset 0) uses inverted sense: a 1 bit makes the pin an input (pad_oe bit 0), a 0 bit makes it drive (pad_oe bit 1). pad_out always equals the output data register.
- R3: Output data register (offset 1) is written directly. Writing a mask to offset 2 sets the masked bits, and writing a mask to offset 3 clears them. Zero bits of the mask leave bits unchanged. Reads at offsets 1, 2 and 3 return the output data register.
- R4: The input register (offset 4) returns pad levels through a SYNC_STAGES-flop synchronizer. With the default of 2, a pad change before an edge is readable after the second following edge.
- R5: With the rising-detect bit (offset 5) enabled, a 0-to-1 pad transition sets the pin's status bit on the third clock edge after the pad change. The bit is set once per edge: after it is cleared it stays clear while the pad stays high.
- R6: With the falling-detect bit (offset 6) enabled, a 1-to-0 transition sets the status bit. With both edge bits enabled, either direction sets it.
- R7: Low-level detect (offset 7) and high-level detect (offset 8) set the status bit on every cycle the enabled level persists, so a clear while the level holds leaves the bit set. With both enabled, either level sets it.
- R8: Status (offset 11) reads the pending bits. Writing 1 clears a bit and writing 0 leaves it unchanged. Bits are held until cleared.
- R9: Writing a mask to offset 9 sets interrupt-enable bits, and writing a mask to offset 10 clears them. Zero mask bits leave them unchanged. Both offsets read back the interrupt-enable register.
- R10: Status bits are recorded whether or not they are enabled. irq is high exactly when some status bit has its enable bit set.
- R11: A write to any of offsets 5 to 8 suppresses event recording for QUIET_CYCLES (default 5) clock edges after the write edge. A condition present throughout is recorded on the next edge after that window.
- R12: Writes to the read-only input register (offset 4) and to unused offsets 12 to 15 change no state. Reads of unused offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register word offset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_data | input | NPINS | Write data or mask |
| rd_data | output | NPINS | Combinational read data for addr |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad drive enable, 1 drives |
| irq | output | 1 | Interrupt, OR of enabled pending bits |

## Verification
The bench builds the block with its defaults: 32 pins, a two-stage synchronizer and a five-cycle quiet window. The full width puts masks that reach bit 31 within reach. The fixed two-stage depth makes the input latency and the three-edge event latency exact, so checks can sample on the precise edge. The five-cycle window lets the bench observe the last suppressed edge and the first recording edge of R11 directly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR      = 4'd0,
        REG_DOUT     = 4'd1,
        REG_DOUT_SET = 4'd2,
        REG_DOUT_CLR = 4'd3,
        REG_DIN      = 4'd4,
        REG_RISE     = 4'd5,
        REG_FALL     = 4'd6,
        REG_LOW      = 4'd7,
        REG_HIGH     = 4'd8,
        REG_IEN_SET  = 4'd9,
        REG_IEN_CLR  = 4'd10,
        REG_STAT     = 4'd11
    } gpio_reg_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
    parameter int N            = 32,
    parameter int QUIET_CYCLES = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    input  logic [N-1:0] rise_en_i,
    input  logic [N-1:0] fall_en_i,
    input  logic [N-1:0] low_en_i,
    input  logic [N-1:0] high_en_i,
    input  logic         cfg_wr_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] status_o
);
    localparam int CW = $clog2(QUIET_CYCLES + 1);

    typedef struct packed {
        logic [N-1:0]  status;
        logic [N-1:0]  prev;
        logic [CW-1:0] quiet;
    } det_s;

    det_s st_d, st_q;
    logic [N-1:0] raw_evt;
    logic [N-1:0] evt;

    always_comb begin
        raw_evt = (rise_en_i & pins_i & ~st_q.prev)
                | (fall_en_i & ~pins_i & st_q.prev)
                | (low_en_i & ~pins_i)
                | (high_en_i & pins_i);
        evt = (st_q.quiet == '0) ? raw_evt : '0;

        st_d        = st_q;
        st_d.prev   = pins_i;
        st_d.status = (st_q.status & ~clr_mask_i) | evt;
        if (cfg_wr_i) begin
            st_d.quiet = CW'(QUIET_CYCLES);
        end else if (st_q.quiet != '0) begin
            st_d.quiet = st_q.quiet - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    // R11
    quiet_blocks_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.quiet != '0) |=> ((st_q.status & ~$past(st_q.status)) == '0));

    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask_i != '0) |=> ((st_q.status & $past(clr_mask_i) & ~$past(evt)) == '0));

    // R8
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask_i == '0) |=> ((st_q.status & $past(st_q.status)) == $past(st_q.status)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_pkg::*;
#(
    parameter int NPINS        = 32,
    parameter int SYNC_STAGES  = 2,
    parameter int QUIET_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  rd_data,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] rise;
        logic [NPINS-1:0] fall;
        logic [NPINS-1:0] low;
        logic [NPINS-1:0] high;
        logic [NPINS-1:0] ien;
    } regs_s;

    regs_s            r_d, r_q;
    logic             cfg_wr;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] din_sync;
    logic [NPINS-1:0] status;

    gpio_pad_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (din_sync)
    );

    gpio_event_detect #(.N(NPINS), .QUIET_CYCLES(QUIET_CYCLES)) detect_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (din_sync),
        .rise_en_i  (r_q.rise),
        .fall_en_i  (r_q.fall),
        .low_en_i   (r_q.low),
        .high_en_i  (r_q.high),
        .cfg_wr_i   (cfg_wr),
        .clr_mask_i (clr_mask),
        .status_o   (status)
    );

    always_comb begin
        r_d      = r_q;
        cfg_wr   = 1'b0;
        clr_mask = '0;
        if (wr_en) begin
            case (gpio_reg_e'(addr))
                REG_DIR:      r_d.dir  = wr_data;
                REG_DOUT:     r_d.dout = wr_data;
                REG_DOUT_SET: r_d.dout = r_q.dout | wr_data;
                REG_DOUT_CLR: r_d.dout = r_q.dout & ~wr_data;
                REG_RISE: begin r_d.rise = wr_data; cfg_wr = 1'b1; end
                REG_FALL: begin r_d.fall = wr_data; cfg_wr = 1'b1; end
                REG_LOW:  begin r_d.low  = wr_data; cfg_wr = 1'b1; end
                REG_HIGH: begin r_d.high = wr_data; cfg_wr = 1'b1; end
                REG_IEN_SET:  r_d.ien  = r_q.ien | wr_data;
                REG_IEN_CLR:  r_d.ien  = r_q.ien & ~wr_data;
                REG_STAT:     clr_mask = wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (gpio_reg_e'(addr))
            REG_DIR:                              rd_data = r_q.dir;
            REG_DOUT, REG_DOUT_SET, REG_DOUT_CLR: rd_data = r_q.dout;
            REG_DIN:                              rd_data = din_sync;
            REG_RISE:                             rd_data = r_q.rise;
            REG_FALL:                             rd_data = r_q.fall;
            REG_LOW:                              rd_data = r_q.low;
            REG_HIGH:                             rd_data = r_q.high;
            REG_IEN_SET, REG_IEN_CLR:             rd_data = r_q.ien;
            REG_STAT:                             rd_data = status;
            default:                              rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.dir <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign pad_oe  = ~r_q.dir;
    assign pad_out = r_q.dout;
    assign irq     = |(status & r_q.ien);

    // R2
    dir_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIR) |=> (pad_oe == ~$past(wr_data)));

    // R3
    dout_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DOUT_SET) |=> ((pad_out & $past(wr_data)) == $past(wr_data)));

    // R3
    dout_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DOUT_CLR) |=> ((pad_out & $past(wr_data)) == '0));

    // R9
    ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_IEN_SET) |=> (r_q.ien == ($past(r_q.ien) | $past(wr_data))));
endmodule

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
    import gpio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_bank dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // entry: {offset[67:64], data[63:32], expected output register[31:0]}
    localparam logic [67:0] VEC [8] = '{
        {4'd1, 32'h0000_FFFF, 32'h0000_FFFF},
        {4'd2, 32'h00FF_0000, 32'h00FF_FFFF},
        {4'd3, 32'h0000_0F0F, 32'h00FF_F0F0},
        {4'd2, 32'h0000_0000, 32'h00FF_F0F0},
        {4'd3, 32'h0000_0000, 32'h00FF_F0F0},
        {4'd3, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'd2, 32'h8000_0001, 32'h8000_0001},
        {4'd1, 32'h1234_5678, 32'h1234_5678}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(4'd0, v);  chk("R1 dir", v, 32'hFFFF_FFFF);
        chk("R1 pad_oe", pad_oe, 32'h0);
        rd(4'd1, v);  chk("R1 dout", v, 32'h0);
        rd(4'd11, v); chk("R1 status", v, 32'h0);
        rd(4'd9, v);  chk("R1 ien", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R3 alias table walk
        foreach (VEC[i]) begin
            wr(VEC[i][67:64], VEC[i][63:32]);
            rd(4'd1, v);
            chk("R3 dout read", v, VEC[i][31:0]);
            chk("R3 pad_out", pad_out, VEC[i][31:0]);
        end
        rd(4'd3, v); chk("R3 clr alias read", v, 32'h1234_5678);

        // R2 direction sense
        wr(4'd0, 32'h0000_00F0);
        chk("R2 pad_oe", pad_oe, 32'hFFFF_FF0F);

        // R4 synchronizer latency
        pad_in = 32'hA5A5_0000;
        cyc(1); rd(4'd4, v); chk("R4 din after one edge", v, 32'h0);
        cyc(1); rd(4'd4, v); chk("R4 din after two edges", v, 32'hA5A5_0000);
        pad_in = 32'h0;
        cyc(4);

        // R5 rising edge
        wr(4'd5, 32'h1);
        cyc(8);
        wr(4'd11, 32'hFFFF_FFFF);
        pad_in[0] = 1'b1;
        cyc(2); rd(4'd11, v); chk("R5 status before third edge", v, 32'h0);
        cyc(1); rd(4'd11, v); chk("R5 status on third edge", v, 32'h1);
        wr(4'd11, 32'h1);
        cyc(4); rd(4'd11, v); chk("R5 once per edge", v, 32'h0);

        // R6 falling and both edges
        wr(4'd6, 32'h1);
        cyc(8);
        pad_in[0] = 1'b0;
        cyc(4); rd(4'd11, v); chk("R6 falling", v, 32'h1);
        wr(4'd11, 32'h1);
        pad_in[0] = 1'b1;
        cyc(4); rd(4'd11, v); chk("R6 both edges rising", v, 32'h1);
        wr(4'd11, 32'h1);

        // R8 partial write-one-to-clear
        wr(4'd5, 32'h0000_0301);
        cyc(8);
        pad_in[9:8] = 2'b11;
        cyc(4); rd(4'd11, v); chk("R8 two pending", v, 32'h300);
        wr(4'd11, 32'h100);
        rd(4'd11, v); chk("R8 one cleared", v, 32'h200);
        wr(4'd11, 32'h0);
        rd(4'd11, v); chk("R8 zero write holds", v, 32'h200);
        wr(4'd11, 32'h200);
        wr(4'd5, 32'h0);
        wr(4'd6, 32'h0);

        // R7 level detection
        wr(4'd7, 32'h0001_0000);
        cyc(8);
        rd(4'd11, v); chk("R7 low level", v, 32'h0001_0000);
        wr(4'd11, 32'h0001_0000);
        rd(4'd11, v); chk("R7 level reasserts", v, 32'h0001_0000);
        pad_in[16] = 1'b1;
        cyc(4);
        wr(4'd11, 32'h0001_0000);
        rd(4'd11, v); chk("R7 low gone", v, 32'h0);
        wr(4'd8, 32'h0001_0000);
        cyc(8);
        rd(4'd11, v); chk("R7 any level", v, 32'h0001_0000);
        wr(4'd7, 32'h0);
        wr(4'd8, 32'h0);
        cyc(8);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd11, v); chk("R7 all clear", v, 32'h0);

        // R10 / R9 enables and irq
        wr(4'd5, 32'h0010_0000);
        cyc(8);
        pad_in[20] = 1'b1;
        cyc(4);
        rd(4'd11, v); chk("R10 recorded while disabled", v, 32'h0010_0000);
        chk("R10 irq masked", {31'h0, irq}, 32'h0);
        wr(4'd9, 32'h0010_0000);
        chk("R10 irq enabled", {31'h0, irq}, 32'h1);
        wr(4'd9, 32'h1);
        rd(4'd10, v); chk("R9 set leaves others", v, 32'h0010_0001);
        wr(4'd10, 32'h0010_0000);
        rd(4'd9, v); chk("R9 clear alias", v, 32'h1);
        chk("R9 irq after clear", {31'h0, irq}, 32'h0);
        wr(4'd9, 32'h0010_0000);
        wr(4'd11, 32'h0010_0000);
        chk("R10 irq after status clear", {31'h0, irq}, 32'h0);
        wr(4'd5, 32'h0);
        cyc(8);
        wr(4'd11, 32'hFFFF_FFFF);

        // R11 quiet window after detect write
        wr(4'd7, 32'h0100_0000);
        cyc(5); rd(4'd11, v); chk("R11 suppressed at fifth edge", v, 32'h0);
        cyc(1); rd(4'd11, v); chk("R11 recorded at sixth edge", v, 32'h0100_0000);
        wr(4'd7, 32'h0);
        cyc(8);
        wr(4'd11, 32'hFFFF_FFFF);

        // R12 writes without effect
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, v); chk("R12 din write ignored", v, pad_in);
        wr(4'd15, 32'hFFFF_FFFF);
        rd(4'd0, v);  chk("R12 dir unchanged", v, 32'h0000_00F0);
        rd(4'd1, v);  chk("R12 dout unchanged", v, 32'h1234_5678);
        rd(4'd9, v);  chk("R12 ien unchanged", v, 32'h0010_0001);
        rd(4'd11, v); chk("R12 status unchanged", v, 32'h0);
        rd(4'd13, v); chk("R12 unused read", v, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule